// File: doc/BRIEF.md
# Serial Character Receiver with Line Error Checks

This block turns an asynchronous serial input into parallel characters. It oversamples the line sixteen times per bit, using a tick that a programmable clock divisor produces. It confirms each start bit near the middle of the bit and then samples every following bit at its centre. It builds characters of seven or eight data bits, sent least significant bit first. An optional odd or even parity bit and one stop bit follow the data bits.

When a character's stop bit is sampled, the block checks the frame. A character that passes every check and finds room downstream goes out as a one-cycle push strobe with its data. Parity mismatches, bad stop bits, break conditions and characters lost to a full buffer each raise their own one-cycle pulse. The receive buffer and all register access lie outside the block.

Top module: `uart_rx_core`

## Requirements
- R1: While reset (active low) is applied and directly after it, the push strobe and all four error pulses are low.
- R2: One bit time lasts 16 × `baudDiv` clock cycles, and a divisor of 0 acts as 1. A frame is a low start bit, then the data bits least significant first, then the optional parity bit, then one stop bit. A valid 8-bit frame (`charSize8` = 1) gives exactly one push with `pushData` equal to the sent byte.
- R3: With `charSize8` = 0 the frame carries 7 data bits. They appear on `pushData[6:0]`, and `pushData[7]` is 0.
- R4: `parityMode` selects the parity bit: 0 or 3 means no parity bit, 1 means odd and 2 means even. Under odd parity the data bits and the parity bit together hold an odd number of ones; under even parity they hold an even number. A mismatch raises `parityErr`, and the character is not pushed.
- R5: A stop bit sampled as 0 raises `frameErr`, and the character is not pushed.
- R6: When all data bits and the stop bit are 0, `breakErr` is raised together with `frameErr`, and nothing is pushed.
- R7: When a frame completes while `fifoFull` is high, `overrunErr` is raised and the character is discarded.
- R8: A low pulse on the line that is back high by the middle of the start bit is ignored. It gives no push and no error, and the next frame is received normally.
- R9: The push strobe and every error pulse last exactly one clock cycle per frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| rxLine | input | 1 | Serial input line; idle level is high |
| baudDiv | input | DIV_W | Clock cycles per oversampling tick |
| charSize8 | input | 1 | 1 selects 8 data bits, 0 selects 7 |
| parityMode | input | 2 | 0/3 none, 1 odd, 2 even |
| fifoFull | input | 1 | The downstream buffer cannot accept a character |
| pushValid | output | 1 | One-cycle strobe carrying a good character |
| pushData | output | 8 | Received character |
| parityErr | output | 1 | Pulse: parity mismatch |
| frameErr | output | 1 | Pulse: stop bit read as 0 |
| breakErr | output | 1 | Pulse: data bits and stop bit all zero |
| overrunErr | output | 1 | Pulse: character lost because the buffer was full |

## Verification
The assertions assume that `baudDiv`, `charSize8`, `parityMode` and `fifoFull` stay constant from the start bit until the completion pulse. They also assume that frames are separated by idle time, so output pulses never fall in consecutive cycles. The stimulus sets every configuration input and the full flag before a frame begins, holds them for the whole frame, and follows each frame with two idle bit times. Random frames draw their data, size, parity mode, parity corruption, stop value, full flag and divisor from a fixed seed. Directed frames cover break, a rejected glitch and a divisor of zero.

// File: rtl/urx_pkg.sv
package urx_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_START, ST_DATA, ST_PARITY, ST_STOP
  } rxState_t;

  typedef struct packed {
    logic takeData;
    logic takeParity;
    logic finish;
  } rxStrobe_t;

  localparam logic [1:0] PAR_ODD  = 2'd1;
  localparam logic [1:0] PAR_EVEN = 2'd2;
endpackage

// File: rtl/urx_ctrl.sv
module urx_ctrl
  import urx_pkg::*;
#(
  parameter int DIV_W  = 16,
  parameter int OVS    = 16,
  parameter int DATA_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [DIV_W-1:0] baudDiv,
  input  logic             charSize8,
  input  logic [1:0]       parityMode,
  input  logic             lineSync,
  input  logic             fallEdge,
  output rxStrobe_t        strb
);
  localparam int SW   = $clog2(OVS);
  localparam int BW   = $clog2(DATA_W);
  localparam int HALF = OVS / 2 - 1;

  rxState_t         state;
  logic [DIV_W-1:0] divCnt;
  logic [DIV_W-1:0] divEff;
  logic [SW-1:0]    sampCnt;
  logic [BW-1:0]    bitIdx;
  logic [BW-1:0]    lastIdx;
  logic             tick;
  logic             midTick;
  logic             parOn;

  assign divEff  = (baudDiv == '0) ? DIV_W'(1) : baudDiv;
  assign tick    = (divCnt == divEff - DIV_W'(1));
  assign midTick = tick && (sampCnt == SW'(OVS - 1));
  assign lastIdx = charSize8 ? BW'(DATA_W - 1) : BW'(DATA_W - 2);
  assign parOn   = (parityMode == PAR_ODD) || (parityMode == PAR_EVEN);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      divCnt  <= '0;
      sampCnt <= '0;
      bitIdx  <= '0;
    end else if (state == ST_IDLE) begin
      divCnt  <= '0;
      sampCnt <= '0;
      bitIdx  <= '0;
      if (fallEdge) state <= ST_START;
    end else begin
      divCnt <= tick ? '0 : divCnt + DIV_W'(1);
      if (tick) sampCnt <= sampCnt + SW'(1);
      case (state)
        ST_START: if (tick && sampCnt == SW'(HALF)) begin
          if (!lineSync) begin
            state   <= ST_DATA;
            sampCnt <= '0;
          end else begin
            state <= ST_IDLE;
          end
        end
        ST_DATA: if (midTick) begin
          bitIdx <= bitIdx + BW'(1);
          if (bitIdx == lastIdx) begin
            bitIdx <= '0;
            state  <= parOn ? ST_PARITY : ST_STOP;
          end
        end
        ST_PARITY: if (midTick) state <= ST_STOP;
        ST_STOP:   if (midTick) state <= ST_IDLE;
        default:   state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    strb.takeData   = (state == ST_DATA)   && midTick;
    strb.takeParity = (state == ST_PARITY) && midTick;
    strb.finish     = (state == ST_STOP)   && midTick;
  end

  AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(strb)); // R2
  AST_FINISH_TO_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    strb.finish |=> (state == ST_IDLE)); // R9
endmodule

// File: rtl/urx_datapath.sv
module urx_datapath
  import urx_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              rxLine,
  input  logic              charSize8,
  input  logic [1:0]        parityMode,
  input  logic              fifoFull,
  input  rxStrobe_t         strb,
  output logic              lineSync,
  output logic              fallEdge,
  output logic              pushValid,
  output logic [DATA_W-1:0] pushData,
  output logic              parityErr,
  output logic              frameErr,
  output logic              breakErr,
  output logic              overrunErr
);
  logic [SYNC_STAGES-1:0] syncReg;
  logic                   lineDly;
  logic [DATA_W-1:0]      shiftReg;
  logic [DATA_W-1:0]      rxData;
  logic                   parBit;
  logic                   expPar;
  logic                   parOn;
  logic                   badPar;
  logic                   badStop;
  logic                   isBreak;

  assign lineSync = syncReg[SYNC_STAGES-1];
  assign fallEdge = lineDly & ~lineSync;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncReg <= '1;
      lineDly <= 1'b1;
    end else begin
      syncReg <= {syncReg[SYNC_STAGES-2:0], rxLine};
      lineDly <= lineSync;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftReg <= '0;
      parBit   <= 1'b0;
    end else begin
      if (strb.takeData)   shiftReg <= {lineSync, shiftReg[DATA_W-1:1]};
      if (strb.takeParity) parBit   <= lineSync;
    end
  end

  always_comb begin
    rxData  = charSize8 ? shiftReg : {1'b0, shiftReg[DATA_W-1:1]};
    parOn   = (parityMode == PAR_ODD) || (parityMode == PAR_EVEN);
    expPar  = (parityMode == PAR_ODD) ? ~(^rxData) : (^rxData);
    badPar  = parOn && (parBit != expPar);
    badStop = !lineSync;
    isBreak = badStop && (rxData == '0);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pushValid  <= 1'b0;
      pushData   <= '0;
      parityErr  <= 1'b0;
      frameErr   <= 1'b0;
      breakErr   <= 1'b0;
      overrunErr <= 1'b0;
    end else begin
      pushValid  <= strb.finish && !fifoFull && !badPar && !badStop;
      parityErr  <= strb.finish && badPar;
      frameErr   <= strb.finish && badStop;
      breakErr   <= strb.finish && isBreak;
      overrunErr <= strb.finish && fifoFull;
      if (strb.finish) pushData <= rxData;
    end
  end

  AST_NO_PUSH_WHEN_FULL: assert property (@(posedge clk) disable iff (!rstN)
    pushValid |-> !$past(fifoFull)); // R7
  AST_OVERRUN_NEEDS_FULL: assert property (@(posedge clk) disable iff (!rstN)
    overrunErr |-> $past(fifoFull)); // R7
  AST_BREAK_WITH_FRAME: assert property (@(posedge clk) disable iff (!rstN)
    breakErr |-> (frameErr && !pushValid)); // R6
  AST_ERR_BLOCKS_PUSH: assert property (@(posedge clk) disable iff (!rstN)
    (parityErr || frameErr) |-> !pushValid); // R4
  AST_SEVEN_BIT_TOP: assert property (@(posedge clk) disable iff (!rstN)
    (pushValid && !$past(charSize8)) |-> !pushData[DATA_W-1]); // R3
  AST_PUSH_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    pushValid |=> !pushValid); // R9
endmodule

// File: rtl/uart_rx_core.sv
module uart_rx_core
  import urx_pkg::*;
#(
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             rxLine,
  input  logic [DIV_W-1:0] baudDiv,
  input  logic             charSize8,
  input  logic [1:0]       parityMode,
  input  logic             fifoFull,
  output logic             pushValid,
  output logic [7:0]       pushData,
  output logic             parityErr,
  output logic             frameErr,
  output logic             breakErr,
  output logic             overrunErr
);
  localparam int DATA_W = 8;

  rxStrobe_t strb;
  logic      lineSync;
  logic      fallEdge;

  urx_ctrl #(.DIV_W(DIV_W), .OVS(16), .DATA_W(DATA_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .baudDiv(baudDiv), .charSize8(charSize8),
    .parityMode(parityMode), .lineSync(lineSync), .fallEdge(fallEdge),
    .strb(strb)
  );

  urx_datapath #(.DATA_W(DATA_W), .SYNC_STAGES(2)) u_dp (
    .clk(clk), .rstN(rstN), .rxLine(rxLine), .charSize8(charSize8),
    .parityMode(parityMode), .fifoFull(fifoFull), .strb(strb),
    .lineSync(lineSync), .fallEdge(fallEdge), .pushValid(pushValid),
    .pushData(pushData), .parityErr(parityErr), .frameErr(frameErr),
    .breakErr(breakErr), .overrunErr(overrunErr)
  );
endmodule

// File: tb/sim_uart_rx_core.sv
module sim_uart_rx_core;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        rxLine = 1'b1;
  logic [15:0] baudDiv = 16'd2;
  logic        charSize8 = 1'b1;
  logic [1:0]  parityMode = 2'd0;
  logic        fifoFull = 1'b0;
  logic        pushValid, parityErr, frameErr, breakErr, overrunErr;
  logic [7:0]  pushData;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  int pushCnt, parCnt, frmCnt, brkCnt, ovrCnt, wideCnt;
  logic [7:0] lastData;
  logic [4:0] prevOut;

  always #(CLK_PERIOD/2) clk = ~clk;

  uart_rx_core u0 (
    .clk(clk), .rstN(rstN), .rxLine(rxLine), .baudDiv(baudDiv),
    .charSize8(charSize8), .parityMode(parityMode), .fifoFull(fifoFull),
    .pushValid(pushValid), .pushData(pushData), .parityErr(parityErr),
    .frameErr(frameErr), .breakErr(breakErr), .overrunErr(overrunErr)
  );

  always @(negedge clk) begin
    if (rstN) begin
      if (pushValid) begin pushCnt++; lastData = pushData; end
      if (parityErr)  parCnt++;
      if (frameErr)   frmCnt++;
      if (breakErr)   brkCnt++;
      if (overrunErr) ovrCnt++;
      if ((prevOut & {pushValid, parityErr, frameErr, breakErr, overrunErr}) != 0) wideCnt++;
      prevOut = {pushValid, parityErr, frameErr, breakErr, overrunErr};
    end else prevOut = '0;
  end

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic clearMon();
    pushCnt = 0; parCnt = 0; frmCnt = 0; brkCnt = 0; ovrCnt = 0; lastData = '0;
  endtask

  function automatic logic [7:0] maskData(input logic [7:0] d, input bit is8);
    return is8 ? d : {1'b0, d[6:0]};
  endfunction

  function automatic logic parityFor(input logic [7:0] d, input logic [1:0] mode);
    return (mode == 2'd1) ? ~(^d) : (^d);
  endfunction

  task automatic holdBit(input logic v, input int cyc);
    rxLine = v;
    repeat (cyc) @(negedge clk);
  endtask

  task automatic sendFrame(input logic [7:0] d, input bit is8, input logic [1:0] mode,
                           input bit flipPar, input logic stopV, input int div);
    int bitCyc;
    logic [7:0] md;
    bitCyc = 16 * ((div == 0) ? 1 : div);
    md = maskData(d, is8);
    holdBit(1'b0, bitCyc);
    for (int i = 0; i < (is8 ? 8 : 7); i++) holdBit(md[i], bitCyc);
    if (mode == 2'd1 || mode == 2'd2) holdBit(parityFor(md, mode) ^ flipPar, bitCyc);
    holdBit(stopV, bitCyc);
    holdBit(1'b1, 2 * bitCyc);
  endtask

  task automatic runFrame(input string tag, input logic [7:0] d, input bit is8,
                          input logic [1:0] mode, input bit flipPar, input logic stopV,
                          input bit full, input int div);
    bit parOn, expPar, expFrm, expBrk, expPush;
    logic [7:0] md;
    @(negedge clk);
    baudDiv = 16'(div); charSize8 = is8; parityMode = mode; fifoFull = full;
    clearMon();
    sendFrame(d, is8, mode, flipPar, stopV, div);
    md = maskData(d, is8);
    parOn = (mode == 2'd1 || mode == 2'd2);
    expPar = parOn && flipPar;
    expFrm = !stopV;
    expBrk = expFrm && (md == 0);
    expPush = !full && !expPar && !expFrm;
    check({tag, " push count"}, pushCnt, int'(expPush));
    if (expPush) check({tag, " data"}, int'(lastData), int'(md));
    check({tag, " parityErr R4"}, parCnt, int'(expPar));
    check({tag, " frameErr R5"}, frmCnt, int'(expFrm));
    check({tag, " breakErr R6"}, brkCnt, int'(expBrk));
    check({tag, " overrunErr R7"}, ovrCnt, int'(full));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    int seed;
    seed = 17;
    void'($urandom(seed));
    clearMon(); wideCnt = 0; prevOut = '0;
    repeat (3) @(negedge clk);
    // R1: outputs quiet in reset
    check("R1 outputs during reset", int'({pushValid, parityErr, frameErr, breakErr, overrunErr}), 0);
    rstN = 1'b1;
    repeat (3) @(negedge clk);
    check("R1 outputs after reset", int'({pushValid, parityErr, frameErr, breakErr, overrunErr}), 0);

    runFrame("R2 8-bit A5", 8'hA5, 1, 2'd0, 0, 1, 0, 2);
    runFrame("R2 8-bit div0", 8'h3C, 1, 2'd0, 0, 1, 0, 0);
    runFrame("R3 7-bit", 8'hD3, 0, 2'd0, 0, 1, 0, 3);
    runFrame("R4 odd ok", 8'h71, 1, 2'd1, 0, 1, 0, 2);
    runFrame("R4 even bad", 8'h71, 1, 2'd2, 1, 1, 0, 2);
    runFrame("R4 mode3 none", 8'h0F, 1, 2'd3, 0, 1, 0, 2);
    runFrame("R5 bad stop", 8'h81, 1, 2'd0, 0, 0, 0, 2);
    runFrame("R6 break", 8'h00, 1, 2'd0, 0, 0, 0, 2);
    runFrame("R7 overrun", 8'h5A, 1, 2'd0, 0, 1, 1, 2);

    // R8: short low pulse rejected, then a normal frame
    @(negedge clk);
    baudDiv = 16'd2; charSize8 = 1'b1; parityMode = 2'd0; fifoFull = 1'b0;
    clearMon();
    holdBit(1'b0, 8);
    holdBit(1'b1, 96);
    check("R8 glitch push", pushCnt, 0);
    check("R8 glitch errors", parCnt + frmCnt + brkCnt + ovrCnt, 0);
    runFrame("R8 after glitch", 8'hC6, 1, 2'd0, 0, 1, 0, 2);

    for (int n = 0; n < 40; n++) begin
      runFrame("R2 random", 8'($urandom), 1'($urandom), 2'($urandom),
               ($urandom % 4) == 0, ($urandom % 8) != 0, ($urandom % 6) == 0,
               2 + int'($urandom % 4));
    end

    check("R9 single-cycle pulses", wideCnt, 0);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule